// File: doc/BRIEF.md
# Condition Register Logic Unit

This block owns a 32-bit condition register split into eight 4-bit fields. When it is given a valid operation, it does one of two things. It can combine two selected condition bits with one of eight two-input boolean functions and write the result into one selected destination bit. Or it can copy a whole 4-bit field onto another field. The extended opcode chooses the operation. The bit and field selectors use big-endian numbering: selector 0 names the most significant bit, or the most significant field.

Other execution units can load a whole field through a separate write port in any cycle. If that write and an operation touch the same bits in the same cycle, the operation wins on those bits. The current register contents are always visible on a plain 32-bit output. An opcode the block does not recognise leaves the register alone and raises a one-cycle illegal-operation flag.

Top module: `cr_logic_unit`

## Requirements
- R1: A synchronous active-high reset clears the whole register to zero and drops the illegal-operation flag.
- R2: Bit selector value n addresses register bit 31 − n, so selector 0 is bit 31 and selector 31 is bit 0. This holds for the destination and for both source selectors.
- R3: With valid high, the destination bit receives f(A, B), where A and B are the two selected source bits. The opcode chooses f: 257 gives AND, 449 gives OR, 255 gives NAND, 193 gives XOR, 33 gives NOR, 289 gives XNOR, 129 gives A AND NOT B, and 417 gives A OR NOT B.
- R4: A boolean operation changes at most the one destination bit. The other 31 bits keep their value.
- R5: With valid high, opcode 0 copies field number `op_fs` into field number `op_fd`. Field number f occupies register bits 31−4f down to 28−4f, and the field's most significant bit lands on bit 31−4f. No other field changes.
- R6: With valid high, any opcode not listed in R3 or R5 leaves the register unchanged. It also drives `illegal_op` high for exactly the one cycle after the edge that sampled it.
- R7: An operation sampled at a rising edge updates the register at that same edge. `cr_out` shows the new value from then on and the old value before it, so a dependent operation may follow in the next cycle.
- R8: With `fld_wr_en` high, the 4-bit `fld_wr_data` is loaded into field number `fld_wr_sel`, using the field numbering of R5, with data bit 3 going to bit 31−4f.
- R9: When an operation and a field write hit the same register bits in one cycle, the operation's value wins on those bits. The remaining bits of the field write still load.
- R10: With `op_valid` low and no field write, the register holds and `illegal_op` stays low, whatever the opcode and selector inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe |
| op_xo | input | 10 | Extended opcode |
| op_bt | input | 5 | Destination bit selector |
| op_ba | input | 5 | Source A bit selector |
| op_bb | input | 5 | Source B bit selector |
| op_fd | input | 3 | Destination field selector for the field copy |
| op_fs | input | 3 | Source field selector for the field copy |
| fld_wr_en | input | 1 | External field write enable |
| fld_wr_sel | input | 3 | External field write target |
| fld_wr_data | input | 4 | External field write value |
| cr_out | output | 32 | Current register contents |
| illegal_op | output | 1 | One-cycle flag for an unrecognised opcode |

## Verification
The bench builds the block with its default eight fields of four bits, so that every selector value from 0 to 31 and every field number from 0 to 7 can be reached. That covers both ends of the reversed bit numbering, a field copied onto itself, and copies between the outermost fields. The same defaults allow a field write to collide with a bit operation inside the same field and with a field copy onto the same field. A reference model in the bench predicts each cycle's register value and flag.

// File: rtl/crl_pkg.sv
package crl_pkg;

    localparam int DEF_FIELDS  = 8;
    localparam int DEF_FIELD_W = 4;
    localparam int XO_W        = 10;

    typedef enum logic [3:0] {
        CROP_NONE,
        CROP_AND,
        CROP_OR,
        CROP_NAND,
        CROP_XOR,
        CROP_NOR,
        CROP_EQV,
        CROP_ANDC,
        CROP_ORC,
        CROP_MOVE
    } crop_e;

    function automatic crop_e xo_to_op(input logic [XO_W-1:0] xo);
        case (xo)
            10'd0:   return CROP_MOVE;
            10'd33:  return CROP_NOR;
            10'd129: return CROP_ANDC;
            10'd193: return CROP_XOR;
            10'd255: return CROP_NAND;
            10'd257: return CROP_AND;
            10'd289: return CROP_EQV;
            10'd417: return CROP_ORC;
            10'd449: return CROP_OR;
            default: return CROP_NONE;
        endcase
    endfunction

    function automatic logic cr_bool(input crop_e op, input logic a, input logic b);
        case (op)
            CROP_AND:  return a & b;
            CROP_OR:   return a | b;
            CROP_NAND: return ~(a & b);
            CROP_XOR:  return a ^ b;
            CROP_NOR:  return ~(a | b);
            CROP_EQV:  return ~(a ^ b);
            CROP_ANDC: return a & ~b;
            CROP_ORC:  return a | ~b;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/crl_decode.sv
module crl_decode
    import crl_pkg::*;
(
    input  logic            valid,
    input  logic [XO_W-1:0] xo,
    output crop_e           kind,
    output logic            bit_en,
    output logic            move_en,
    output logic            bad_op
);

    always_comb begin
        kind    = xo_to_op(xo);
        move_en = valid && (kind == CROP_MOVE);
        bad_op  = valid && (kind == CROP_NONE);
        bit_en  = valid && (kind != CROP_MOVE) && (kind != CROP_NONE);
    end

endmodule

// File: rtl/crl_bitop.sv
module crl_bitop
    import crl_pkg::*;
#(
    parameter  int CR_W  = 32,
    localparam int SEL_W = $clog2(CR_W)
) (
    input  logic             en,
    input  crop_e            kind,
    input  logic [CR_W-1:0]  cr,
    input  logic [SEL_W-1:0] bt,
    input  logic [SEL_W-1:0] ba,
    input  logic [SEL_W-1:0] bb,
    output logic [CR_W-1:0]  mask,
    output logic             res
);

    localparam logic [SEL_W-1:0] MSB_IDX = SEL_W'(CR_W - 1);

    // big-endian selectors: index n lives at physical bit (CR_W-1-n)
    logic [SEL_W-1:0] pos_t, pos_a, pos_b;

    always_comb begin
        pos_t = MSB_IDX - bt;
        pos_a = MSB_IDX - ba;
        pos_b = MSB_IDX - bb;
        res   = cr_bool(kind, cr[pos_a], cr[pos_b]);
    end

    for (genvar i = 0; i < CR_W; i++) begin : g_dst
        assign mask[i] = en && (pos_t == SEL_W'(i));
    end

endmodule

// File: rtl/crl_fmove.sv
module crl_fmove #(
    parameter  int N_FIELDS = 8,
    parameter  int FIELD_W  = 4,
    localparam int CR_W     = N_FIELDS * FIELD_W,
    localparam int FSEL_W   = $clog2(N_FIELDS)
) (
    input  logic              en,
    input  logic [CR_W-1:0]   cr,
    input  logic [FSEL_W-1:0] fd,
    input  logic [FSEL_W-1:0] fs,
    output logic [CR_W-1:0]   mask,
    output logic [FIELD_W-1:0] fdata
);

    // field number f sits in slot (N_FIELDS-1-f), slot 0 being the LSBs
    always_comb begin
        fdata = '0;
        for (int f = 0; f < N_FIELDS; f++) begin
            if (fs == FSEL_W'(f))
                fdata = cr[(N_FIELDS-1-f)*FIELD_W +: FIELD_W];
        end
    end

    for (genvar f = 0; f < N_FIELDS; f++) begin : g_dst
        assign mask[(N_FIELDS-1-f)*FIELD_W +: FIELD_W] =
            {FIELD_W{en && (fd == FSEL_W'(f))}};
    end

endmodule

// File: rtl/cr_logic_unit.sv
module cr_logic_unit
    import crl_pkg::*;
#(
    parameter  int N_FIELDS = DEF_FIELDS,
    parameter  int FIELD_W  = DEF_FIELD_W,
    localparam int CR_W     = N_FIELDS * FIELD_W,
    localparam int BSEL_W   = $clog2(CR_W),
    localparam int FSEL_W   = $clog2(N_FIELDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic [XO_W-1:0]    op_xo,
    input  logic [BSEL_W-1:0]  op_bt,
    input  logic [BSEL_W-1:0]  op_ba,
    input  logic [BSEL_W-1:0]  op_bb,
    input  logic [FSEL_W-1:0]  op_fd,
    input  logic [FSEL_W-1:0]  op_fs,
    input  logic               fld_wr_en,
    input  logic [FSEL_W-1:0]  fld_wr_sel,
    input  logic [FIELD_W-1:0] fld_wr_data,
    output logic [CR_W-1:0]    cr_out,
    output logic               illegal_op
);

    crop_e              kind;
    logic               bit_en, mv_en, bad_op;
    logic [CR_W-1:0]    cr_q, cr_d;
    logic [CR_W-1:0]    bit_mask, mv_mask, ext_mask;
    logic               bit_res;
    logic [FIELD_W-1:0] mv_data;

    crl_decode u_dec (
        .valid   (op_valid),
        .xo      (op_xo),
        .kind    (kind),
        .bit_en  (bit_en),
        .move_en (mv_en),
        .bad_op  (bad_op)
    );

    crl_bitop #(.CR_W(CR_W)) u_bit (
        .en   (bit_en),
        .kind (kind),
        .cr   (cr_q),
        .bt   (op_bt),
        .ba   (op_ba),
        .bb   (op_bb),
        .mask (bit_mask),
        .res  (bit_res)
    );

    crl_fmove #(.N_FIELDS(N_FIELDS), .FIELD_W(FIELD_W)) u_mv (
        .en    (mv_en),
        .cr    (cr_q),
        .fd    (op_fd),
        .fs    (op_fs),
        .mask  (mv_mask),
        .fdata (mv_data)
    );

    for (genvar f = 0; f < N_FIELDS; f++) begin : g_ext
        assign ext_mask[(N_FIELDS-1-f)*FIELD_W +: FIELD_W] =
            {FIELD_W{fld_wr_en && (fld_wr_sel == FSEL_W'(f))}};
    end

    // per-bit merge: operation result beats the external field write
    for (genvar i = 0; i < CR_W; i++) begin : g_merge
        localparam int LANE = i % FIELD_W;
        assign cr_d[i] = bit_mask[i] ? bit_res       :
                         mv_mask[i]  ? mv_data[LANE] :
                         ext_mask[i] ? fld_wr_data[LANE] :
                                       cr_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cr_q       <= '0;
            illegal_op <= 1'b0;
        end else begin
            cr_q       <= cr_d;
            illegal_op <= bad_op;
        end
    end

    assign cr_out = cr_q;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cr_q == '0 && !illegal_op));

    p_single_bit_r4: assert property (@(posedge clk) disable iff (rst)
        (bit_en && !fld_wr_en) |=> ($countones(cr_q ^ $past(cr_q)) <= 1));

    p_move_confined_r5: assert property (@(posedge clk) disable iff (rst)
        (mv_en && !fld_wr_en) |=> (((cr_q ^ $past(cr_q)) & ~$past(mv_mask)) == '0));

    p_illegal_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (bad_op && !fld_wr_en) |=> ($stable(cr_q) && illegal_op));

    p_illegal_cause_r6: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> $past(op_valid));

    p_ext_confined_r8: assert property (@(posedge clk) disable iff (rst)
        (fld_wr_en && !op_valid) |=> (((cr_q ^ $past(cr_q)) & ~$past(ext_mask)) == '0));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !fld_wr_en) |=> ($stable(cr_q) && !illegal_op));

endmodule

// File: tb/cr_logic_unit_tb_top.sv
module cr_logic_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [9:0]  op_xo = '0;
    logic [4:0]  op_bt = '0, op_ba = '0, op_bb = '0;
    logic [2:0]  op_fd = '0, op_fs = '0;
    logic        fld_wr_en = 1'b0;
    logic [2:0]  fld_wr_sel = '0;
    logic [3:0]  fld_wr_data = '0;
    logic [31:0] cr_out;
    logic        illegal_op;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] cr;
        logic        ill;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] model = '0;
    logic [31:0] prev_model = '0;

    always #5 clk = ~clk;

    cr_logic_unit dut_i (
        .clk         (clk),
        .rst         (rst),
        .op_valid    (op_valid),
        .op_xo       (op_xo),
        .op_bt       (op_bt),
        .op_ba       (op_ba),
        .op_bb       (op_bb),
        .op_fd       (op_fd),
        .op_fs       (op_fs),
        .fld_wr_en   (fld_wr_en),
        .fld_wr_sel  (fld_wr_sel),
        .fld_wr_data (fld_wr_data),
        .cr_out      (cr_out),
        .illegal_op  (illegal_op)
    );

    function automatic logic getb(input logic [31:0] v, input int n);
        return v[31 - n];
    endfunction

    // driver: applies one cycle of stimulus and queues the predicted result
    task automatic drive(input bit v, input int xo, input int bt, input int ba,
                         input int bb, input int fd, input int fs, input bit we,
                         input int ws, input int wd, input string tag);
        logic [31:0] nxt;
        logic        ill, a, b, r;
        @(negedge clk);
        op_valid = v; op_xo = 10'(xo);
        op_bt = 5'(bt); op_ba = 5'(ba); op_bb = 5'(bb);
        op_fd = 3'(fd); op_fs = 3'(fs);
        fld_wr_en = we; fld_wr_sel = 3'(ws); fld_wr_data = 4'(wd);
        nxt = model;
        ill = 1'b0;
        if (we)
            for (int k = 0; k < 4; k++) nxt[31 - 4*ws - k] = wd[3 - k];
        if (v) begin
            a = getb(model, ba);
            b = getb(model, bb);
            r = 1'b0;
            case (xo)
                257: r = a && b;
                449: r = a || b;
                255: r = !(a && b);
                193: r = (a != b);
                33:  r = !(a || b);
                289: r = (a == b);
                129: r = a && !b;
                417: r = a || !b;
                default: ;
            endcase
            case (xo)
                257, 449, 255, 193, 33, 289, 129, 417: nxt[31 - bt] = r;
                0: for (int k = 0; k < 4; k++) nxt[31 - 4*fd - k] = model[31 - 4*fs - k];
                default: ill = 1'b1;
            endcase
        end
        prev_model = model;
        model = nxt;
        sb_q.push_back('{cr: nxt, ill: ill, tag: tag});
    endtask

    task automatic bitop(input int xo, input int bt, input int ba, input int bb, input string tag);
        drive(1, xo, bt, ba, bb, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic fmove(input int fd, input int fs, input string tag);
        drive(1, 0, 0, 0, 0, fd, fs, 0, 0, 0, tag);
    endtask

    task automatic fwrite(input int ws, input int wd, input string tag);
        drive(0, 0, 0, 0, 0, 0, 0, 1, ws, wd, tag);
    endtask

    // monitor: compares each result just after the edge that produced it
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (cr_out !== e.cr || illegal_op !== e.ill) begin
                errors++;
                $display("FAIL %s: cr_out=%h illegal_op=%b expected cr_out=%h illegal_op=%b",
                         e.tag, cr_out, illegal_op, e.cr, e.ill);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog: run did not finish, actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int xo_list[8] = '{257, 449, 255, 193, 33, 289, 129, 417};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        checks++;
        if (cr_out !== 32'h0 || illegal_op !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: cr_out=%h illegal_op=%b expected cr_out=00000000 illegal_op=0",
                     cr_out, illegal_op);
        end

        // R8: load every field, field 0 at the MSBs -> 5A3C96F1
        fwrite(0, 4'h5, "R8");
        fwrite(1, 4'hA, "R8");
        fwrite(2, 4'h3, "R8");
        fwrite(3, 4'hC, "R8");
        fwrite(4, 4'h9, "R8");
        fwrite(5, 4'h6, "R8");
        fwrite(6, 4'hF, "R8");
        fwrite(7, 4'h1, "R8");

        // R10: valid low with busy-looking inputs
        drive(0, 257, 3, 0, 1, 2, 5, 0, 0, 0, "R10");
        drive(0, 5,   31, 31, 0, 7, 0, 0, 0, 0, "R10");

        // R3 / R2 / R4: every function, end selectors included
        bitop(257, 0,  1,  2,  "R3 and");
        bitop(449, 31, 0,  31, "R2 or ends");
        bitop(255, 5,  4,  6,  "R3 nand");
        bitop(193, 16, 0,  31, "R3 xor");
        bitop(33,  30, 29, 28, "R3 nor");
        bitop(289, 8,  31, 1,  "R3 eqv");
        bitop(129, 12, 24, 25, "R3 andc");
        bitop(417, 20, 3,  28, "R3 orc");
        bitop(193, 7,  7,  7,  "R4 self xor");

        // R3 / R4 sweep with shifting selectors
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 4; j++)
                bitop(xo_list[i], (i*4 + j*7) % 32, (i*5 + j) % 32, (31 - i*3 - j) & 31, "R3 sweep");

        // R5: field copies
        fmove(7, 0, "R5 copy 0->7");
        fmove(2, 2, "R5 self copy");
        fmove(0, 5, "R5 copy 5->0");
        fmove(4, 1, "R5 copy 1->4");

        // R6: unrecognised opcodes, then the flag must drop
        bitop(5,    3, 1, 2, "R6 xo 5");
        bitop(16,   9, 9, 9, "R6 xo 16");
        bitop(1023, 0, 0, 0, "R6 xo 1023");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 flag drop");

        // R7: value not visible before the edge, dependent op next cycle
        bitop(193, 2, 2, 3, "R7 update");
        #1;
        checks++;
        if (cr_out !== prev_model) begin
            errors++;
            $display("FAIL R7 early: cr_out=%h expected %h before edge", cr_out, prev_model);
        end
        bitop(257, 4, 2, 2, "R7 dependent");
        fmove(6, 0, "R7 dependent copy");

        // R9: collisions between operations and the field write
        drive(1, 257, 1, 8, 9, 0, 0, 1, 0, 4'h0, "R9 bit vs write");
        drive(1, 449, 6, 30, 31, 0, 0, 1, 1, 4'hF, "R9 bit vs write");
        drive(1, 0, 0, 0, 0, 3, 6, 1, 3, 4'h0, "R9 copy vs write");
        drive(1, 0, 0, 0, 0, 4, 7, 1, 6, 4'hA, "R9 disjoint");
        drive(1, 5, 0, 0, 0, 0, 0, 1, 2, 4'h7, "R9 illegal with write");

        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 final");
        repeat (3) @(posedge clk);
        #2;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule